// File: doc/BRIEF.md
# Freezable Clock Register Window

This block puts a small set of time-of-day registers on a RAM-style byte bus. The registers sit in a 16-byte window at the top of the address space. Each user-visible time byte is a shadow copy of the running time counters, which are outside the block. A one-second strobe reloads every shadow byte at once from the live counter value.

A control byte in the same window has two freeze bits. The read-freeze bit stops the reloads so that software can read a consistent snapshot while the counters keep running. The write-freeze bit also stops the reloads and opens the time bytes to bus writes. When software clears the write-freeze bit, the block sends the edited snapshot to the counters as a one-cycle load.

Bus accesses behave like synchronous SRAM cycles. A refresh never stalls a bus access.

Top module: `clkreg_window`

## Requirements
- R1: An access hits the window only when address bits [12:4] are all ones, which is 1FF0h to 1FFFh. An access outside the window writes nothing, and its read leaves `rd_en` low.
- R2: A read is a cycle with `ce_n`=0, `oe_n`=0 and `we_n`=1. For a read that hits the window, `rd_data` holds the addressed byte on the next cycle and `rd_en`=1. After any other cycle, `rd_en`=0 and `rd_data`=0.
- R3: Window offsets 0 to 7 are the time bytes, and offset k maps to bits [8k+7:8k] of `live_time`. Offset 8 is the control byte. Offsets 9 to 15 read as 0, and writes to them are dropped.
- R4: When `sec_tick` is high and both freeze bits are 0, every time byte takes the `live_time` value of that cycle.
- R5: While control bit 6 (read-freeze) is 1, ticks leave the time bytes unchanged. After the bit is cleared, the next tick reloads them.
- R6: A freeze bit is evaluated as it stood before the cycle in which it is written. A tick in that same cycle therefore still reloads the time bytes, and later ticks do not.
- R7: While control bit 7 (write-freeze) is 1, ticks are blocked and a bus write (`ce_n`=0, `we_n`=0) to a time byte stores the data. While bit 7 is 0, bus writes to time bytes are dropped.
- R8: A control write that changes bit 7 from 1 to 0 raises `load_stb` for exactly one cycle, on the next cycle. At that point `load_time` holds the time bytes as they stood before the write. No other cycle raises `load_stb`.
- R9: After reset the control byte, all time bytes, `rd_data`, `rd_en` and `load_stb` are 0.
- R10: A control write stores all eight bits, and a read of offset 8 returns them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W (13) | Byte address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| rd_en | output | 1 | Read data valid and bus driven |
| sec_tick | input | 1 | One-second refresh strobe |
| live_time | input | N_TIME*8 (64) | Current value of the running counters |
| load_stb | output | 1 | One-cycle load pulse to the counters |
| load_time | output | N_TIME*8 (64) | Value the counters take on `load_stb` |

## Verification
Read data and `rd_en` follow the strobe cycle after one register stage. A tick's new values can be read back by a read issued in the next cycle, and so they appear two cycles after the tick. A control write that clears the write-freeze bit produces `load_stb` one cycle later.

The bench drives every input on the falling edge and samples on the next falling edge. Each check therefore looks at exactly the cycle the response is due in. The bench model updates its expected state with the same one-edge delay, so a freeze written together with a tick is predicted as a completed reload.

// File: rtl/clkreg_pkg.sv
package clkreg_pkg;

    localparam int BYTE_W    = 8;
    localparam int WIN_OFF_W = 4;
    localparam int WR_BIT    = 7;
    localparam int RD_BIT    = 6;

    typedef struct packed {
        logic                 rd;
        logic                 wr;
        logic                 hit;
        logic [WIN_OFF_W-1:0] off;
        logic [BYTE_W-1:0]    data;
    } bus_op_t;

endpackage

// File: rtl/clkreg_decode.sv
module clkreg_decode
    import clkreg_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic                ce_n,
    input  logic                we_n,
    input  logic                oe_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [BYTE_W-1:0]   wr_data,
    output bus_op_t             op
);

    always_comb begin
        op.wr   = !ce_n && !we_n;
        op.rd   = !ce_n && !oe_n && we_n;
        op.hit  = &addr[ADDR_W-1:WIN_OFF_W];
        op.off  = addr[WIN_OFF_W-1:0];
        op.data = wr_data;
    end

endmodule

// File: rtl/clkreg_shadow.sv
module clkreg_shadow
    import clkreg_pkg::*;
#(
    parameter int N_TIME = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  bus_op_t                         op,
    input  logic                            sec_tick,
    input  logic [N_TIME-1:0][BYTE_W-1:0]   live_time,
    output logic [N_TIME-1:0][BYTE_W-1:0]   shadow,
    output logic [BYTE_W-1:0]               ctrl,
    output logic                            load_stb,
    output logic [N_TIME-1:0][BYTE_W-1:0]   load_time
);

    localparam int CTRL_OFF = N_TIME;

    typedef struct packed {
        logic [N_TIME-1:0][BYTE_W-1:0] shad;
        logic [BYTE_W-1:0]             ctrl;
        logic                          stb;
        logic [N_TIME-1:0][BYTE_W-1:0] ld;
    } shadow_state_t;

    shadow_state_t s_d, s_q;
    logic          refresh;
    logic          ctrl_wr;
    logic          time_wr;

    always_comb begin
        s_d     = s_q;
        s_d.stb = 1'b0;
        refresh = sec_tick && !s_q.ctrl[WR_BIT] && !s_q.ctrl[RD_BIT];
        ctrl_wr = op.wr && op.hit && (op.off == WIN_OFF_W'(CTRL_OFF));
        time_wr = op.wr && op.hit && s_q.ctrl[WR_BIT];

        if (refresh) begin
            s_d.shad = live_time;
        end

        for (int i = 0; i < N_TIME; i++) begin
            if (time_wr && (op.off == WIN_OFF_W'(i))) begin
                s_d.shad[i] = op.data;
            end
        end

        if (ctrl_wr) begin
            s_d.ctrl = op.data;
            if (s_q.ctrl[WR_BIT] && !op.data[WR_BIT]) begin
                s_d.stb = 1'b1;
                s_d.ld  = s_q.shad;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign shadow    = s_q.shad;
    assign ctrl      = s_q.ctrl;
    assign load_stb  = s_q.stb;
    assign load_time = s_q.ld;

endmodule

// File: rtl/clkreg_rdport.sv
module clkreg_rdport
    import clkreg_pkg::*;
#(
    parameter int N_TIME = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  bus_op_t                         op,
    input  logic [N_TIME-1:0][BYTE_W-1:0]   shadow,
    input  logic [BYTE_W-1:0]               ctrl,
    output logic [BYTE_W-1:0]               rd_data,
    output logic                            rd_en
);

    localparam int CTRL_OFF = N_TIME;

    typedef struct packed {
        logic              en;
        logic [BYTE_W-1:0] data;
    } rd_state_t;

    rd_state_t         r_d, r_q;
    logic [BYTE_W-1:0] sel;

    always_comb begin
        sel = '0;
        for (int i = 0; i < N_TIME; i++) begin
            if (op.off == WIN_OFF_W'(i)) begin
                sel = shadow[i];
            end
        end
        if (op.off == WIN_OFF_W'(CTRL_OFF)) begin
            sel = ctrl;
        end
        r_d.en   = op.rd && op.hit;
        r_d.data = r_d.en ? sel : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_data = r_q.data;
    assign rd_en   = r_q.en;

endmodule

// File: rtl/clkreg_window.sv
module clkreg_window
    import clkreg_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int N_TIME = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ce_n,
    input  logic                       we_n,
    input  logic                       oe_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [7:0]                 wr_data,
    output logic [7:0]                 rd_data,
    output logic                       rd_en,
    input  logic                       sec_tick,
    input  logic [N_TIME*8-1:0]        live_time,
    output logic                       load_stb,
    output logic [N_TIME*8-1:0]        load_time
);

    bus_op_t                        op;
    logic [N_TIME-1:0][BYTE_W-1:0]  shadow_w;
    logic [N_TIME-1:0][BYTE_W-1:0]  load_w;
    logic [BYTE_W-1:0]              ctrl_w;

    clkreg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .ce_n    (ce_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .addr    (addr),
        .wr_data (wr_data),
        .op      (op)
    );

    clkreg_shadow #(.N_TIME(N_TIME)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .sec_tick  (sec_tick),
        .live_time (live_time),
        .shadow    (shadow_w),
        .ctrl      (ctrl_w),
        .load_stb  (load_stb),
        .load_time (load_w)
    );

    clkreg_rdport #(.N_TIME(N_TIME)) u_rdport (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .shadow  (shadow_w),
        .ctrl    (ctrl_w),
        .rd_data (rd_data),
        .rd_en   (rd_en)
    );

    assign load_time = load_w;

endmodule

// File: rtl/clkreg_window_chk.sv
module clkreg_window_chk #(
    parameter int ADDR_W = 13,
    parameter int N_TIME = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ce_n,
    input logic                we_n,
    input logic                oe_n,
    input logic [ADDR_W-1:0]   addr,
    input logic                sec_tick,
    input logic [N_TIME*8-1:0] live_time,
    input logic [7:0]          ctrl_w,
    input logic [N_TIME*8-1:0] shadow_w,
    input logic                rd_en,
    input logic                load_stb
);

    logic win_hit;
    logic time_wr;
    assign win_hit = &addr[ADDR_W-1:4];
    assign time_wr = !ce_n && !we_n && win_hit && (32'(addr[3:0]) < N_TIME);

    // R1
    rd_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> $past(win_hit));

    // R2
    rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> $past(!ce_n && !oe_n && we_n));

    // R4
    tick_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && ctrl_w[7:6] == 2'b00) |=> (shadow_w == $past(live_time)));

    // R5
    unfrozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_w[7] && (ctrl_w[6] || !sec_tick)) |=> $stable(shadow_w));

    // R7
    write_frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_w[7] && !time_wr) |=> $stable(shadow_w));

    // R8
    load_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> !load_stb);

    // R8
    load_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> ($past(ctrl_w[7]) && !ctrl_w[7]));

endmodule

bind clkreg_window clkreg_window_chk #(.ADDR_W(ADDR_W), .N_TIME(N_TIME)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .addr      (addr),
    .sec_tick  (sec_tick),
    .live_time (live_time),
    .ctrl_w    (ctrl_w),
    .shadow_w  (shadow_w),
    .rd_en     (rd_en),
    .load_stb  (load_stb)
);

// File: tb/clkreg_window_tb_top.sv
`timescale 1ns/1ps
module clkreg_window_tb_top;

    localparam int ADDR_W = 13;
    localparam int N_TIME = 8;
    localparam logic [12:0] WIN = 13'h1FF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [12:0] addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        rd_en;
    logic        sec_tick = 1'b0;
    logic [63:0] live_time = '0;
    logic        load_stb;
    logic [63:0] load_time;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0]  m_shad [N_TIME];
    logic [7:0]  m_ctrl;

    always #4 clk = ~clk;

    clkreg_window #(.ADDR_W(ADDR_W), .N_TIME(N_TIME)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .rd_en(rd_en),
        .sec_tick(sec_tick), .live_time(live_time),
        .load_stb(load_stb), .load_time(load_time)
    );

    function automatic bit in_win(input logic [12:0] a);
        return &a[12:4];
    endfunction

    function automatic logic [7:0] reg_val(input logic [3:0] off);
        if (int'(off) < N_TIME) return m_shad[off];
        if (int'(off) == N_TIME) return m_ctrl;
        return 8'h00;
    endfunction

    function automatic logic [63:0] shad_flat();
        logic [63:0] v;
        for (int i = 0; i < N_TIME; i++) v[i*8 +: 8] = m_shad[i];
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One bus cycle, entered and left at a falling edge.
    task automatic step(input bit do_rd, input bit do_wr, input logic [12:0] a,
                        input logic [7:0] d, input bit tick, input string tag);
        logic [7:0]  e_data;
        bit          e_en;
        bit          e_stb;
        logic [63:0] e_ld;
        logic [7:0]  pre_ctrl;
        logic [63:0] lv;
        lv = {$urandom, $urandom};
        ce_n = !(do_rd || do_wr);
        we_n = !do_wr;
        oe_n = do_wr ? 1'($urandom) : !do_rd;
        addr = a;
        wr_data = d;
        sec_tick = tick;
        live_time = lv;
        pre_ctrl = m_ctrl;
        e_en = do_rd && !do_wr && in_win(a);
        e_data = e_en ? reg_val(a[3:0]) : 8'h00;
        e_stb = 1'b0;
        e_ld = shad_flat();
        if (tick && pre_ctrl[7:6] == 2'b00)
            for (int i = 0; i < N_TIME; i++) m_shad[i] = lv[i*8 +: 8];
        if (do_wr && in_win(a)) begin
            if (int'(a[3:0]) < N_TIME && pre_ctrl[7]) m_shad[a[3:0]] = d;
            if (int'(a[3:0]) == N_TIME) begin
                m_ctrl = d;
                e_stb = pre_ctrl[7] && !d[7];
            end
        end
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; sec_tick = 1'b0;
        check(rd_en == e_en, {tag, " rd_en"}, 64'(rd_en), 64'(e_en));
        check(rd_data == e_data, {tag, " rd_data"}, 64'(rd_data), 64'(e_data));
        check(load_stb == e_stb, "R8 load_stb", 64'(load_stb), 64'(e_stb));
        if (e_stb) check(load_time == e_ld, "R8 load_time", load_time, e_ld);
    endtask

    task automatic rd(input logic [3:0] off, input string tag);
        step(1'b1, 1'b0, WIN | 13'(off), 8'h00, 1'b0, tag);
    endtask

    task automatic wr(input logic [3:0] off, input logic [7:0] d, input bit tick, input string tag);
        step(1'b0, 1'b1, WIN | 13'(off), d, tick, tag);
    endtask

    task automatic rd_all(input string tag);
        for (int i = 0; i < N_TIME; i++) rd(4'(i), tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < N_TIME; i++) m_shad[i] = 8'h00;
        m_ctrl = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check(rd_en == 1'b0 && rd_data == 8'h00, "R9 outputs", 64'(rd_data), 64'h0);
        check(load_stb == 1'b0, "R9 load_stb", 64'(load_stb), 64'h0);
        rd(4'h8, "R9");
        rd_all("R9");

        // R4: plain tick refresh
        step(1'b0, 1'b0, 13'h0, 8'h00, 1'b1, "R4");
        rd_all("R4");

        // R7 / R3 / R8: edit under write freeze, then commit
        wr(4'h8, 8'h80, 1'b0, "R7");
        step(1'b0, 1'b0, 13'h0, 8'h00, 1'b1, "R7");
        wr(4'h3, 8'hA5, 1'b0, "R7");
        wr(4'h0, 8'h59, 1'b0, "R7");
        wr(4'h9, 8'h55, 1'b0, "R3");
        rd(4'h9, "R3");
        rd(4'hF, "R3");
        rd_all("R7");
        wr(4'h8, 8'h00, 1'b0, "R8");
        wr(4'h2, 8'h77, 1'b0, "R7");
        rd(4'h2, "R7");

        // R6 / R5: read freeze written in a tick cycle
        wr(4'h8, 8'h40, 1'b1, "R6");
        rd_all("R6");
        step(1'b0, 1'b0, 13'h0, 8'h00, 1'b1, "R5");
        rd_all("R5");
        wr(4'h8, 8'h00, 1'b0, "R5");
        step(1'b0, 1'b0, 13'h0, 8'h00, 1'b1, "R5");
        rd_all("R5");

        // R1: accesses outside the window
        step(1'b0, 1'b1, 13'h0FF8, 8'h40, 1'b0, "R1");
        step(1'b0, 1'b1, 13'h1FE8, 8'h80, 1'b0, "R1");
        rd(4'h8, "R1");
        step(1'b1, 1'b0, 13'h1FE8, 8'h00, 1'b0, "R1");

        // R10: control byte holds all bits
        wr(4'h8, 8'h2B, 1'b0, "R10");
        rd(4'h8, "R10");

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            int kind;
            logic [12:0] a;
            bit tk;
            kind = int'($urandom_range(0, 9));
            tk = ($urandom_range(0, 5) == 0);
            a = ($urandom_range(0, 7) == 0) ? 13'($urandom) : (WIN | 13'($urandom_range(0, 15)));
            case (kind)
                0, 1:    step(1'b0, 1'b1, WIN | 13'h8, 8'($urandom) & 8'hC0 | 8'($urandom_range(0, 3)), tk, "R10");
                2, 3:    step(1'b0, 1'b1, a, 8'($urandom), tk, "R7");
                4:       step(1'b0, 1'b0, 13'h0, 8'h00, tk, "R4");
                default: step(1'b1, 1'b0, a, 8'h00, tk, "R2");
            endcase
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule